// File: doc/BRIEF.md
# Sixteen-State Viterbi Add-Compare-Select with Odd-Even Lane Grouping

This block performs the add-compare-select stage of a Viterbi decoder with a 16-state trellis (constraint length 5). Path metrics are kept in lanes that are grouped by parity. Lanes 0 to 7 hold the even states and lanes 8 to 15 hold the odd states. With this layout, the two predecessors of every butterfly sit in lanes `j` and `j+8`, and a data-parallel datapath reaches them through a fixed pairing instead of an irregular exchange.

Each step pulse does the following in one registered update:
- adds the branch metrics,
- selects the smaller candidate for each successor state and records which predecessor won,
- renormalises the metrics if any of them has grown into the upper half of its range,
- permutes the results back into the even-then-odd lane order for the next step.

Traceback, branch-metric generation and bit decisions are handled outside the block.

A small controller has two states, `ST_IDLE` and `ST_UPDATED`:
- Reset places it in `ST_IDLE`.
- A step pulse in either state moves it to `ST_UPDATED`, so back-to-back pulses keep it there.
- A cycle without a pulse returns it to `ST_IDLE`.

`valid_o` is high exactly while the controller is in `ST_UPDATED`.

Top module: `viterbi_acs`

## Requirements
- R1: While `rst_n` is low, the controller enters `ST_IDLE` and `valid_o` is 0. Lane 0 (state 0) gets metric 0, every other lane gets `INIT_METRIC` (default 1024), and all decision bits are 0.
- R2: In both `metric_o` and `decision_o`, lane k (k < 8) carries state 2k and lane 8+k carries state 2k+1. Lane l of `metric_o` occupies bits [12l+11:12l].
- R3: For butterfly j, the same-branch metric is bits [8j+7:8j] of `bm_same_i` and the cross-branch metric is the same field of `bm_cross_i`. The candidates are:
  - new state j = min(M(2j)+same, M(2j+1)+cross);
  - new state j+8 = min(M(2j)+cross, M(2j+1)+same).
- R4: The decision bit of a state is 1 only when the candidate from the odd predecessor is strictly smaller. A tie gives 0, which selects the even predecessor.
- R5: After selection, if any of the 16 selected sums is 2048 or more, all 16 are reduced by their minimum before they are stored. Otherwise they are stored unchanged. The stored values keep the low 12 bits.
- R6: While `step_en` is 0, metrics and decisions hold their values whatever the branch-metric inputs are.
- R7: `valid_o` is 1 in the cycle after a cycle with `step_en` high, and 0 after a cycle with `step_en` low.
- R8: Consecutive cycles with `step_en` high each perform one full trellis step on the previous step's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Perform one trellis step this cycle |
| bm_same_i | input | 64 | Eight same-branch metrics, one per butterfly |
| bm_cross_i | input | 64 | Eight cross-branch metrics, one per butterfly |
| metric_o | output | 192 | Sixteen path metrics in grouped lane order |
| decision_o | output | 16 | Survivor decision per state, grouped lane order |
| valid_o | output | 1 | Results of the previous cycle's step are present |

## Verification
Every result of a step appears one clock edge after the cycle in which `step_en` was sampled high: the metrics, the decisions and `valid_o`. The bench drives its inputs on the falling edge and compares all outputs on the next falling edge, half a cycle after that update. During bursts of back-to-back steps, the result of each step is checked on the falling edge at which the following step's inputs are driven. Hold behaviour is checked after several idle cycles with changing branch metrics.

// File: rtl/viterbi_acs_pkg.sv
package viterbi_acs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_UPDATED = 1'b1
    } acs_state_e;

endpackage

// File: rtl/acs_butterfly.sv
module acs_butterfly #(
    parameter int METRIC_W = 12,
    parameter int BM_W     = 8
) (
    input  logic [METRIC_W-1:0] m_even_i,
    input  logic [METRIC_W-1:0] m_odd_i,
    input  logic [BM_W-1:0]     bm_same_i,
    input  logic [BM_W-1:0]     bm_cross_i,
    output logic [METRIC_W:0]   upper_o,
    output logic [METRIC_W:0]   lower_o,
    output logic                upper_dec_o,
    output logic                lower_dec_o
);
    localparam int SUM_W = METRIC_W + 1;

    logic [SUM_W-1:0] ev_ext, od_ext, same_ext, cross_ext;
    logic [SUM_W-1:0] up_even, up_odd, lo_even, lo_odd;

    always_comb begin
        ev_ext    = {1'b0, m_even_i};
        od_ext    = {1'b0, m_odd_i};
        same_ext  = {{(SUM_W-BM_W){1'b0}}, bm_same_i};
        cross_ext = {{(SUM_W-BM_W){1'b0}}, bm_cross_i};
        up_even   = ev_ext + same_ext;
        up_odd    = od_ext + cross_ext;
        lo_even   = ev_ext + cross_ext;
        lo_odd    = od_ext + same_ext;
        // odd predecessor must be strictly better; ties favour the even one
        upper_dec_o = (up_odd < up_even);
        lower_dec_o = (lo_odd < lo_even);
        upper_o     = upper_dec_o ? up_odd : up_even;
        lower_o     = lower_dec_o ? lo_odd : lo_even;
    end
endmodule

// File: rtl/odd_even_regroup.sv
module odd_even_regroup #(
    parameter int N = 16,
    parameter int W = 13
) (
    input  logic [N*W-1:0] nat_i,
    output logic [N*W-1:0] grp_o
);
    localparam int HALF = N / 2;

    for (genvar k = 0; k < HALF; k++) begin : g_lane
        assign grp_o[k*W +: W]          = nat_i[(2*k)*W +: W];
        assign grp_o[(HALF+k)*W +: W]   = nat_i[(2*k+1)*W +: W];
    end
endmodule

// File: rtl/metric_renorm.sv
module metric_renorm #(
    parameter int N  = 16,
    parameter int MW = 12
) (
    input  logic [N*(MW+1)-1:0] sum_i,
    output logic [N*MW-1:0]     metric_o
);
    localparam int SW = MW + 1;

    logic [SW-1:0] min_v;
    logic          hit;

    always_comb begin
        min_v = sum_i[SW-1:0];
        hit   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sum_i[i*SW +: SW] < min_v) min_v = sum_i[i*SW +: SW];
            if (|sum_i[i*SW+MW-1 +: 2])    hit   = 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            if (hit) metric_o[i*MW +: MW] = MW'(sum_i[i*SW +: SW] - min_v);
            else     metric_o[i*MW +: MW] = MW'(sum_i[i*SW +: SW]);
        end
    end
endmodule

// File: rtl/viterbi_acs.sv
module viterbi_acs
    import viterbi_acs_pkg::*;
#(
    parameter int NUM_STATES  = 16,
    parameter int METRIC_W    = 12,
    parameter int BM_W        = 8,
    parameter int INIT_METRIC = 1024
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           step_en,
    input  logic [NUM_STATES/2*BM_W-1:0]   bm_same_i,
    input  logic [NUM_STATES/2*BM_W-1:0]   bm_cross_i,
    output logic [NUM_STATES*METRIC_W-1:0] metric_o,
    output logic [NUM_STATES-1:0]          decision_o,
    output logic                           valid_o
);
    localparam int HALF  = NUM_STATES / 2;
    localparam int SUM_W = METRIC_W + 1;
    localparam logic [METRIC_W-1:0] INIT_W = METRIC_W'(INIT_METRIC);

    acs_state_e state_q, state_d;

    logic [NUM_STATES*METRIC_W-1:0] metric_q, metric_d;
    logic [NUM_STATES-1:0]          dec_q, dec_nat, dec_grp;
    logic [NUM_STATES*SUM_W-1:0]    sum_nat, sum_grp;

    // butterflies: predecessors 2j and 2j+1 live in lanes j and j+HALF
    for (genvar j = 0; j < HALF; j++) begin : g_bfly
        acs_butterfly #(.METRIC_W(METRIC_W), .BM_W(BM_W)) u_bfly (
            .m_even_i   (metric_q[j*METRIC_W +: METRIC_W]),
            .m_odd_i    (metric_q[(HALF+j)*METRIC_W +: METRIC_W]),
            .bm_same_i  (bm_same_i[j*BM_W +: BM_W]),
            .bm_cross_i (bm_cross_i[j*BM_W +: BM_W]),
            .upper_o    (sum_nat[j*SUM_W +: SUM_W]),
            .lower_o    (sum_nat[(HALF+j)*SUM_W +: SUM_W]),
            .upper_dec_o(dec_nat[j]),
            .lower_dec_o(dec_nat[HALF+j])
        );
    end

    odd_even_regroup #(.N(NUM_STATES), .W(SUM_W)) u_grp_metric (
        .nat_i(sum_nat),
        .grp_o(sum_grp)
    );

    odd_even_regroup #(.N(NUM_STATES), .W(1)) u_grp_dec (
        .nat_i(dec_nat),
        .grp_o(dec_grp)
    );

    metric_renorm #(.N(NUM_STATES), .MW(METRIC_W)) u_renorm (
        .sum_i   (sum_grp),
        .metric_o(metric_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = step_en ? ST_UPDATED : ST_IDLE;
            ST_UPDATED: state_d = step_en ? ST_UPDATED : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // metric and decision storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_STATES; l++) begin
                metric_q[l*METRIC_W +: METRIC_W] <= (l == 0) ? '0 : INIT_W;
            end
            dec_q <= '0;
        end else if (step_en) begin
            metric_q <= metric_d;
            dec_q    <= dec_grp;
        end
    end

    // outputs
    always_comb begin
        valid_o    = (state_q == ST_UPDATED);
        metric_o   = metric_q;
        decision_o = dec_q;
    end
endmodule

// File: rtl/viterbi_acs_checks.sv
module viterbi_acs_checks #(
    parameter int NUM_STATES = 16,
    parameter int METRIC_W   = 12,
    parameter int BM_W       = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           step_en,
    input logic [NUM_STATES/2*BM_W-1:0]   bm_same_i,
    input logic [NUM_STATES/2*BM_W-1:0]   bm_cross_i,
    input logic [NUM_STATES*METRIC_W-1:0] metric_o,
    input logic [NUM_STATES-1:0]          decision_o,
    input logic                           valid_o
);
    // R1: a reset cycle leaves state 0 at zero, no decisions, no valid
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || (metric_o[METRIC_W-1:0] == '0 && decision_o == '0 && !valid_o)));

    // R7: valid follows a step by one cycle
    p_valid_after_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> valid_o);

    p_no_valid_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> !valid_o);

    // R6: without a step, nothing stored changes
    p_metric_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(metric_o));

    p_decision_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(decision_o));
endmodule

bind viterbi_acs viterbi_acs_checks #(
    .NUM_STATES(NUM_STATES),
    .METRIC_W  (METRIC_W),
    .BM_W      (BM_W)
) u_checks (.*);

// File: tb/viterbi_acs_test.sv
module viterbi_acs_test;
    localparam int NS   = 16;
    localparam int HB   = 8;
    localparam int MW   = 12;
    localparam int BW   = 8;
    localparam int INIT = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step_en = 1'b0;
    logic [HB*BW-1:0]  bm_same = '0;
    logic [HB*BW-1:0]  bm_cross = '0;
    logic [NS*MW-1:0]  metric_o;
    logic [NS-1:0]     decision_o;
    logic              valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit renorm_seen = 1'b0;

    int mdl[NS];
    int dmdl[NS];

    always #4 clk = ~clk;

    viterbi_acs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .bm_same_i (bm_same),
        .bm_cross_i(bm_cross),
        .metric_o  (metric_o),
        .decision_o(decision_o),
        .valid_o   (valid_o)
    );

    function automatic int lane_of(int s);
        return (s % 2 == 0) ? s / 2 : HB + s / 2;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            mdl[s]  = (s == 0) ? 0 : INIT;
            dmdl[s] = 0;
        end
    endtask

    // R3, R4, R5 reference step in natural state order
    task automatic model_step(input logic [HB*BW-1:0] bs, input logic [HB*BW-1:0] bc);
        int nm[NS];
        int mn;
        bit big;
        for (int j = 0; j < HB; j++) begin
            int sa, sb, e_up, o_up, e_lo, o_lo;
            sa = int'(bs[j*BW +: BW]);
            sb = int'(bc[j*BW +: BW]);
            e_up = mdl[2*j] + sa;   o_up = mdl[2*j+1] + sb;
            e_lo = mdl[2*j] + sb;   o_lo = mdl[2*j+1] + sa;
            dmdl[j]    = (o_up < e_up) ? 1 : 0;
            nm[j]      = (o_up < e_up) ? o_up : e_up;
            dmdl[j+HB] = (o_lo < e_lo) ? 1 : 0;
            nm[j+HB]   = (o_lo < e_lo) ? o_lo : e_lo;
        end
        mn = nm[0];
        big = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (nm[s] < mn) mn = nm[s];
            if (nm[s] >= 2048) big = 1'b1;
        end
        if (big) renorm_seen = 1'b1;
        for (int s = 0; s < NS; s++) mdl[s] = (big ? nm[s] - mn : nm[s]) & 4095;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NS*MW-1:0] act, input logic [NS*MW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // R2 lane mapping applied to the model before comparing
    task automatic check_outputs(input string req, input bit exp_valid);
        logic [NS*MW-1:0] em;
        logic [NS-1:0]    ed;
        for (int s = 0; s < NS; s++) begin
            em[lane_of(s)*MW +: MW] = MW'(mdl[s]);
            ed[lane_of(s)]          = dmdl[s][0];
        end
        check(metric_o === em, req, "metrics", metric_o, em);
        check(decision_o === ed, req, "decisions", {{(NS*MW-NS){1'b0}}, decision_o},
              {{(NS*MW-NS){1'b0}}, ed});
        check(valid_o === exp_valid, "R7", "valid", {{(NS*MW-1){1'b0}}, valid_o},
              {{(NS*MW-1){1'b0}}, exp_valid});
    endtask

    // burst of n back-to-back steps (R8 when n > 1); mode picks the pattern
    task automatic burst(input int n, input int mode, input string req);
        for (int i = 0; i < n; i++) begin
            logic [HB*BW-1:0] a, b;
            @(negedge clk);
            if (i > 0) check_outputs(req, 1'b1);
            for (int j = 0; j < HB; j++) begin
                case (mode)
                    0: begin a[j*BW +: BW] = 8'd0;   b[j*BW +: BW] = 8'd0;   end
                    1: begin a[j*BW +: BW] = 8'd200; b[j*BW +: BW] = 8'd0;   end
                    2: begin a[j*BW +: BW] = 8'd255; b[j*BW +: BW] = 8'd255; end
                    default: begin
                        a[j*BW +: BW] = 8'($urandom_range(0, 255));
                        b[j*BW +: BW] = ($urandom_range(0, 3) == 0) ? a[j*BW +: BW]
                                                                    : 8'($urandom_range(0, 255));
                    end
                endcase
            end
            bm_same  = a;
            bm_cross = b;
            step_en  = 1'b1;
            model_step(a, b);
        end
        @(negedge clk);
        step_en = 1'b0;
        check_outputs(req, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state, also visible while reset is still held
        check_outputs("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1", 1'b0);

        // R4 ties: all branch metrics zero, equal predecessors pick even
        burst(1, 0, "R4");
        // R3/R4 odd predecessor wins strictly
        burst(2, 1, "R3");

        // R6: idle cycles with changing inputs
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            bm_same  = {$urandom, $urandom};
            bm_cross = {$urandom, $urandom};
        end
        @(negedge clk);
        check_outputs("R6", 1'b0);

        // R5: heavy constant branch metrics push metrics over the threshold
        burst(12, 2, "R5");
        checks++;
        if (!renorm_seen) begin
            fails++;
            $display("FAIL R5 renormalisation never triggered: actual 0 expected 1");
        end

        // R2/R8: random bursts with idle gaps
        for (int r = 0; r < 60; r++) begin
            burst($urandom_range(1, 5), 3, "R8");
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        // R1: reset mid-run restores initial metrics
        @(negedge clk);
        rst_n = 1'b0;
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        model_reset();
        check_outputs("R1", 1'b0);
        rst_n = 1'b1;
        burst(3, 3, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule